// File: doc/BRIEF.md
# UART Auto-Baud Detector

This block finds the bit rate of a serial host by listening to the raw receive line while the host keeps sending the byte 0x00. With one start bit and eight zero data bits, the line stays low for nine bit times before the stop bit pulls it high again. The detector counts that low stretch in system clock cycles and turns it into the divisor for a companion UART that samples at 16 times the bit rate. It rounds the divisor to the nearest integer. It then raises a locked flag and holds the divisor steady. A low stretch that is too long for the slowest supported rate, or too short to give a usable divisor, raises an error flag instead.

The detector is controlled by a single enable. While enable is low the block sits in OFF with every output cleared. When enable rises it moves to WAIT_IDLE. There it needs `IDLE_MIN` consecutive high samples of the synchronised line before it moves to ARMED, so a falling edge in the middle of a byte is never taken as a start. In ARMED, a falling edge moves it to MEASURE, and that first low sample is counted. In MEASURE, the line returning high moves it to LOCKED if the rounded quotient is at least one and to ERROR if the quotient is zero. The count reaching `MAX_LOW` while the line is still low also moves it to ERROR. LOCKED and ERROR are held until enable falls, which returns the block to OFF from any state. The default `MAX_LOW` of 65535 covers a 40 MHz clock at 9600 bps, where the low stretch lasts 37,500 cycles.

Top module: `uart_autobaud`

## Requirements
- R1: After reset, and from the second clock after `en` falls, `locked` and `err` are 0. `div` is 0 by the third clock after `en` falls.
- R2: The `rx` line passes through two flip-flops before use. After `en` rises, a falling edge is accepted only after `IDLE_MIN` consecutive high samples. Falling edges that come earlier are ignored.
- R3: A low stretch of N clock cycles gives `div` = floor((N + OVS*BITS/2) / (OVS*BITS)) - 1. With OVS=16 and BITS=9, N=1440 gives 9 and N=720 gives 4.
- R4: The result rounds to the nearest value. With OVS=16 and BITS=9, N=1511 gives 9 and N=1512 gives 10.
- R5: `locked` rises after the line returns high. While `en` stays high, `div` and `locked` then stay unchanged, and later low stretches are ignored.
- R6: The low counter stops at `MAX_LOW`. A stretch of exactly `MAX_LOW` cycles locks. A longer stretch raises `err`, and `locked` stays 0.
- R7: A stretch with a quotient of zero (N < OVS*BITS/2, so N=71 with the bench values) raises `err`. N=72 locks with `div` = 0.
- R8: `locked` and `err` are never 1 at the same time. Either one stays set until `en` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Enables detection; low returns the block to OFF |
| rx | input | 1 | Raw, unsynchronised receive line |
| div | output | DIV_W | Computed baud divisor |
| locked | output | 1 | Divisor is valid and held |
| err | output | 1 | The measured low stretch was out of range |

## Verification
The bench builds the block with OVS=16 and BITS=9, which keep the real oversampling ratio, so the 144-cycle quotient step and its 72-cycle rounding offset fall at realistic points. It shrinks `MAX_LOW` to 4095 and `IDLE_MIN` to 32. With these values both ends of the range fit in a short run: the 4095/4096 saturation boundary, and the 71/72 quotient-zero boundary. The idle-qualification rule can also be tested with a pulse that starts only a few cycles after enable.

// File: rtl/ab_pkg.sv
package ab_pkg;
    typedef enum logic [2:0] {
        S_OFF,
        S_WAIT_IDLE,
        S_ARMED,
        S_MEASURE,
        S_LOCKED,
        S_ERROR
    } ab_state_t;
endpackage

// File: rtl/ab_sync.sv
module ab_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_raw,
    output logic rx_s,
    output logic fall
);
    logic ff1, ff2, prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ff1  <= 1'b1;
            ff2  <= 1'b1;
            prev <= 1'b1;
        end else begin
            ff1  <= rx_raw;
            ff2  <= ff1;
            prev <= ff2;
        end
    end

    assign rx_s = ff2;
    assign fall = prev & ~ff2;
endmodule

// File: rtl/ab_meter.sv
module ab_meter #(
    parameter int MAX_LOW = 65535,
    parameter int OVS     = 16,
    parameter int BITS    = 9,
    localparam int SPAN   = OVS * BITS,
    localparam int HALF   = SPAN / 2,
    localparam int Q_MAX  = (MAX_LOW + HALF) / SPAN,
    localparam int Q_W    = $clog2(Q_MAX + 1),
    localparam int LEN_W  = $clog2(MAX_LOW + 1),
    localparam int PH_W   = $clog2(SPAN)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           inc,
    output logic [Q_W-1:0] quot,
    output logic           sat
);
    logic [LEN_W-1:0] len;
    logic [PH_W-1:0]  phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len   <= '0;
            phase <= PH_W'(HALF);
            quot  <= '0;
        end else if (start) begin
            len   <= LEN_W'(1);
            phase <= PH_W'(HALF + 1);
            quot  <= '0;
        end else if (inc && !sat) begin
            len <= len + 1'b1;
            if (phase == PH_W'(SPAN - 1)) begin
                phase <= '0;
                quot  <= quot + 1'b1;
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end

    assign sat = (len == LEN_W'(MAX_LOW));

    // R6
    len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sat) && !$past(start) |-> len == $past(len));

    // R3
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase < PH_W'(SPAN));
endmodule

// File: rtl/uart_autobaud.sv
module uart_autobaud #(
    parameter int MAX_LOW  = 65535,
    parameter int OVS      = 16,
    parameter int BITS     = 9,
    parameter int IDLE_MIN = 64,
    localparam int SPAN    = OVS * BITS,
    localparam int DIV_W   = $clog2((MAX_LOW + SPAN / 2) / SPAN + 1),
    localparam int IDLE_W  = $clog2(IDLE_MIN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             rx,
    output logic [DIV_W-1:0] div,
    output logic             locked,
    output logic             err
);
    import ab_pkg::*;

    ab_state_t         state, nstate;
    logic              rx_s, fall, sat, m_start, m_inc;
    logic [DIV_W-1:0]  quot;
    logic [IDLE_W-1:0] idle_cnt;
    logic [DIV_W-1:0]  div_q;

    ab_sync sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_raw (rx),
        .rx_s   (rx_s),
        .fall   (fall)
    );

    ab_meter #(.MAX_LOW(MAX_LOW), .OVS(OVS), .BITS(BITS)) meter_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (m_start),
        .inc   (m_inc),
        .quot  (quot),
        .sat   (sat)
    );

    assign m_start = (state == S_ARMED) && fall && en;
    assign m_inc   = (state == S_MEASURE) && !rx_s;

    always_comb begin
        nstate = state;
        unique case (state)
            S_OFF:       if (en) nstate = S_WAIT_IDLE;
            S_WAIT_IDLE: if (rx_s && idle_cnt == IDLE_W'(IDLE_MIN - 1)) nstate = S_ARMED;
            S_ARMED:     if (fall) nstate = S_MEASURE;
            S_MEASURE: begin
                if (rx_s)      nstate = (quot == '0) ? S_ERROR : S_LOCKED;
                else if (sat)  nstate = S_ERROR;
            end
            S_LOCKED:    nstate = S_LOCKED;
            S_ERROR:     nstate = S_ERROR;
            default:     nstate = S_OFF;
        endcase
        if (!en) nstate = S_OFF;
    end

    // state register, idle qualifier and divisor latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_OFF;
            idle_cnt <= '0;
            div_q    <= '0;
        end else begin
            state <= nstate;
            if (state == S_WAIT_IDLE && rx_s && idle_cnt != IDLE_W'(IDLE_MIN))
                idle_cnt <= idle_cnt + 1'b1;
            else
                idle_cnt <= '0;
            if (state == S_OFF)
                div_q <= '0;
            else if (state == S_MEASURE && rx_s && en && quot != '0)
                div_q <= quot - 1'b1;
        end
    end

    // outputs
    always_comb begin
        div    = div_q;
        locked = (state == S_LOCKED);
        err    = (state == S_ERROR);
    end

    // R8
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(locked && err));

    // R5
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && en) |=> (locked && $stable(div)));

    // R1
    disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!locked && !err));

    // R6
    err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(state) == S_MEASURE);

    // R2
    arm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_MEASURE) && $past(state) == S_ARMED |-> $past(fall));
endmodule

// File: tb/uart_autobaud_tb.sv
module uart_autobaud_tb_top;
    localparam int MAX_LOW  = 4095;
    localparam int IDLE_MIN = 32;
    localparam int DIV_W    = $clog2((MAX_LOW + 72) / 144 + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic rx = 1'b1;
    logic [DIV_W-1:0] div;
    logic locked, err;
    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    uart_autobaud #(.MAX_LOW(MAX_LOW), .OVS(16), .BITS(9), .IDLE_MIN(IDLE_MIN)) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .rx(rx),
        .div(div), .locked(locked), .err(err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic low_pulse(input int n);
        @(negedge clk);
        rx = 1'b0;
        wait_cyc(n);
        rx = 1'b1;
        wait_cyc(160);
    endtask

    task automatic restart();
        @(negedge clk);
        en = 1'b0;
        wait_cyc(3);
        chk("R1 locked after disable", int'(locked), 0);
        chk("R1 err after disable", int'(err), 0);
        chk("R1 div after disable", int'(div), 0);
        en = 1'b1;
        wait_cyc(IDLE_MIN + 10);
    endtask

    task automatic measure(input string req, input int n, input int exp_div, input bit exp_err);
        restart();
        low_pulse(n);
        chk({req, " err"}, int'(err), int'(exp_err));
        chk({req, " locked"}, int'(locked), int'(!exp_err));
        if (!exp_err) chk({req, " div"}, int'(div), exp_div);
    endtask

    task automatic t_reset();
        wait_cyc(2);
        chk("R1 reset locked", int'(locked), 0);
        chk("R1 reset err", int'(err), 0);
        chk("R1 reset div", int'(div), 0);
        rst_n = 1'b1;
        wait_cyc(2);
    endtask

    task automatic t_idle_rule();
        @(negedge clk);
        en = 1'b0;
        wait_cyc(3);
        en = 1'b1;
        wait_cyc(5);
        low_pulse(1440);
        chk("R2 early edge ignored", int'(locked), 0);
        low_pulse(720);
        chk("R2 armed after idle locked", int'(locked), 1);
        chk("R2 armed after idle div", int'(div), 4);
    endtask

    task automatic t_hold();
        measure("R3 nominal", 1440, 9, 1'b0);
        low_pulse(720);
        chk("R5 later pulse ignored div", int'(div), 9);
        chk("R5 later pulse ignored locked", int'(locked), 1);
        chk("R8 no err while locked", int'(err), 0);
    endtask

    task automatic t_err_sticky();
        measure("R7 short", 71, 0, 1'b1);
        low_pulse(1440);
        chk("R8 err sticky", int'(err), 1);
        chk("R8 no lock while err", int'(locked), 0);
    endtask

    initial begin
        t_reset();
        t_hold();
        measure("R3 half rate", 720, 4, 1'b0);
        measure("R4 round down", 1511, 9, 1'b0);
        measure("R4 round up", 1512, 10, 1'b0);
        measure("R7 minimum", 72, 0, 1'b0);
        t_err_sticky();
        measure("R6 at limit", MAX_LOW, 27, 1'b0);
        measure("R6 over limit", MAX_LOW + 1, 0, 1'b1);
        t_idle_rule();
        restart();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule